// File: doc/BRIEF.md
# Packed Palette Memory with Output Colour Conversion

This block holds a 256-entry colour palette for a display pipeline. Software sees it as 128 words of 32 bits. Each word packs two 16-bit palette entries side by side. A bus port reads and writes those raw words. A second port takes an 8-bit pixel index, picks the matching 16-bit entry, and returns that colour converted to the pixel format the display side expects.

The raw words are stored exactly as written. Conversion happens on the way out of the lookup port, so changing the output format needs no rewrite of the palette. Each entry carries three 5-bit channels. Each channel is first widened to 8 bits, then cut down to the field width of the chosen format. The format comes from a static two-bit select: 3-3-2 byte, 5-5-5, 5-6-5 or 8-8-8. Narrower formats sit in the low bits of a 24-bit result, with zeros above them.

Top module: `lcdpal_lookup`

## Requirements
- R1: After reset every stored word is zero, `bus_rdata` is zero and `lk_valid_o` is low; a lookup of any index then returns zero.
- R2: Word n holds palette entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. Pixel index i selects word i>>1, and index bit 0 picks the half.
- R3: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Bit 15 has no effect on the lookup result.
- R4: With `depth_sel`=0 the result is an 8-bit value in `lk_color[7:0]`: red[4:2] in bits 7:5, green[4:2] in bits 4:2, blue[4:3] in bits 1:0. Bits [23:8] are zero.
- R5: With `depth_sel`=1 the result is red in bits [14:10], green in [9:5] and blue in [4:0]. Bits [23:15] are zero.
- R6: With `depth_sel`=2 the result is red in bits [15:11], green in [10:6] with bit 5 zero, and blue in [4:0]. Bits [23:16] are zero.
- R7: With `depth_sel`=3 each channel is shifted left by 3 with zero low bits. Red sits in [23:16], green in [15:8] and blue in [7:0].
- R8: A lookup presented with `lk_req` high produces `lk_valid_o` high and its colour on the next cycle. `lk_valid_o` is low in a cycle after no request.
- R9: A lookup issued in the same cycle as a bus write to the same word returns the colour from the word's old contents. A lookup in the following cycle sees the new contents.
- R10: `bus_rdata` shows, one cycle later, the word addressed by `bus_addr`. A read of the word being written in the same cycle returns the old value.
- R11: A write stores all 32 bits, both intensity bits included, and a later bus read returns them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the raw word at `bus_addr` |
| bus_addr | input | 7 | Raw word address |
| bus_wdata | input | 32 | Word to store |
| bus_rdata | output | 32 | Word read at `bus_addr`, registered |
| depth_sel | input | 2 | Output format: 0=3-3-2, 1=5-5-5, 2=5-6-5, 3=8-8-8 |
| lk_req | input | 1 | Lookup request |
| lk_index | input | 8 | Pixel index of the lookup |
| lk_valid_o | output | 1 | Result valid, one cycle after `lk_req` |
| lk_color | output | 24 | Converted colour, zero-extended |

## Verification
Each word is loaded with distinct values in its two halves. Lookups of even and odd indices are then compared, which shows whether the half is selected correctly and not swapped. Some channel values differ only in bits that one format discards, for example red patterns that vary only in their low two bits. Run under all four formats, these show whether each truncation and shift keeps the right bits. Words with the intensity bits set and clear are read back over the bus and looked up, which separates storage, where those bits must survive, from conversion, where they must vanish. Writes and lookups to the same word in the same cycle, then in consecutive cycles, show the old-then-new ordering.

// File: rtl/lcdpal_pkg.sv
package lcdpal_pkg;

  localparam int CH_W  = 5;
  localparam int WIDE_W = 8;
  localparam int OUT_W = 24;

  typedef enum logic [1:0] {
    FMT_332 = 2'd0,
    FMT_555 = 2'd1,
    FMT_565 = 2'd2,
    FMT_888 = 2'd3
  } depth_e;

  // Entry layout: blue in the top field, red in the bottom one
  typedef struct packed {
    logic [CH_W-1:0] blu;
    logic [CH_W-1:0] grn;
    logic [CH_W-1:0] red;
  } rgb5_t;

  typedef struct packed {
    logic [WIDE_W-1:0] red;
    logic [WIDE_W-1:0] grn;
    logic [WIDE_W-1:0] blu;
  } rgb8_t;

  function automatic logic [WIDE_W-1:0] widen(input logic [CH_W-1:0] c);
    return {c, {(WIDE_W-CH_W){1'b0}}};
  endfunction

  function automatic rgb8_t expand(input rgb5_t p);
    rgb8_t w;
    w.red = widen(p.red);
    w.grn = widen(p.grn);
    w.blu = widen(p.blu);
    return w;
  endfunction

  function automatic logic [OUT_W-1:0] pack_332(input rgb8_t w);
    return {16'd0, w.red[7:5], w.grn[7:5], w.blu[7:6]};
  endfunction

  function automatic logic [OUT_W-1:0] pack_555(input rgb8_t w);
    return {9'd0, w.red[7:3], w.grn[7:3], w.blu[7:3]};
  endfunction

  function automatic logic [OUT_W-1:0] pack_565(input rgb8_t w);
    return {8'd0, w.red[7:3], w.grn[7:2], w.blu[7:3]};
  endfunction

  function automatic logic [OUT_W-1:0] pack_888(input rgb8_t w);
    return {w.red, w.grn, w.blu};
  endfunction

  function automatic logic [OUT_W-1:0] pack_fmt(input int fmt, input rgb8_t w);
    case (fmt)
      0:       return pack_332(w);
      1:       return pack_555(w);
      2:       return pack_565(w);
      default: return pack_888(w);
    endcase
  endfunction

endpackage

// File: rtl/lcdpal_store.sv
module lcdpal_store #(
  parameter int WORDS = 128,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic          rb_en,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data
);

  logic [DW-1:0] mem [WORDS];

  // Nonblocking update: both read ports see the pre-write contents
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra_data <= '0;
      rb_data <= '0;
    end else begin
      ra_data <= mem[ra_addr];
      if (rb_en) rb_data <= mem[rb_addr];
    end
  end

endmodule

// File: rtl/lcdpal_unpack.sv
module lcdpal_unpack
  import lcdpal_pkg::*;
#(
  parameter int DW      = 32,
  parameter int ENTRY_W = 16,
  localparam int HALVES = DW / ENTRY_W,
  localparam int HS_W   = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic [DW-1:0]   word,
  input  logic [HS_W-1:0] half_sel,
  output rgb5_t           chan
);

  logic [ENTRY_W-1:0] entries [HALVES];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign entries[h] = word[h*ENTRY_W +: ENTRY_W];
  end

  logic [ENTRY_W-1:0] picked;
  assign picked = entries[half_sel];

  // The top bit of each entry is dropped here
  assign chan = rgb5_t'(picked[$bits(rgb5_t)-1:0]);

endmodule

// File: rtl/lcdpal_convert.sv
module lcdpal_convert
  import lcdpal_pkg::*;
#(
  parameter int NFMT = 4
) (
  input  rgb5_t            chan,
  input  logic [1:0]       fmt,
  output logic [OUT_W-1:0] color
);

  rgb8_t wide;
  assign wide = expand(chan);

  logic [OUT_W-1:0] cand [NFMT];

  for (genvar f = 0; f < NFMT; f++) begin : g_fmt
    assign cand[f] = pack_fmt(f, wide);
  end

  assign color = cand[fmt];

endmodule

// File: rtl/lcdpal_lookup.sv
module lcdpal_lookup
  import lcdpal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int ENTRY_W = 16,
  parameter int DW      = 32,
  localparam int PER_WORD = DW / ENTRY_W,
  localparam int WORDS    = ENTRIES / PER_WORD,
  localparam int AW       = $clog2(WORDS),
  localparam int IW       = $clog2(ENTRIES),
  localparam int HS_W     = $clog2(PER_WORD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [1:0]       depth_sel,
  input  logic             lk_req,
  input  logic [IW-1:0]    lk_index,
  output logic             lk_valid_o,
  output logic [OUT_W-1:0] lk_color
);

  // Named events for the checker
  logic            wr_fire;
  logic            lk_fire;
  logic [AW-1:0]   lk_word;
  logic [HS_W-1:0] lk_half;

  assign wr_fire = bus_we;
  assign lk_fire = lk_req;
  assign lk_word = lk_index[IW-1:HS_W];
  assign lk_half = lk_index[HS_W-1:0];

  logic [DW-1:0]   lk_raw;
  logic [HS_W-1:0] half_q;

  lcdpal_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .ra_addr (bus_addr),
    .ra_data (bus_rdata),
    .rb_en   (lk_fire),
    .rb_addr (lk_word),
    .rb_data (lk_raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid_o <= 1'b0;
      half_q     <= '0;
    end else begin
      lk_valid_o <= lk_fire;
      if (lk_fire) half_q <= lk_half;
    end
  end

  rgb5_t chan;

  lcdpal_unpack #(.DW(DW), .ENTRY_W(ENTRY_W)) u_unpack (
    .word     (lk_raw),
    .half_sel (half_q),
    .chan     (chan)
  );

  lcdpal_convert #(.NFMT(4)) u_conv (
    .chan  (chan),
    .fmt   (depth_sel),
    .color (lk_color)
  );

endmodule

// File: rtl/lcdpal_chk.sv
module lcdpal_chk #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_fire,
  input logic          lk_valid_o,
  input logic [1:0]    depth_sel,
  input logic [23:0]   lk_color,
  input logic          wr_fire,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata
);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R8: valid tracks request with one cycle delay
  a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> lk_valid_o);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fire |=> !lk_valid_o);

  // R4: byte format leaves upper bits clear
  a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_o && depth_sel == 2'd0) |-> lk_color[23:8] == 16'd0);

  // R5: 15-bit format leaves upper bits clear
  a_r5_555_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_o && depth_sel == 2'd1) |-> lk_color[23:15] == 9'd0);

  // R6: 16-bit format, green lsb always clear
  a_r6_565_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_o && depth_sel == 2'd2) |-> (lk_color[23:16] == 8'd0 && !lk_color[5]));

  // R7: widened channels carry zero low bits
  a_r7_888_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_o && depth_sel == 2'd3) |->
      (lk_color[2:0] == 3'd0 && lk_color[10:8] == 3'd0 && lk_color[18:16] == 3'd0));

  // R10 and R11: a word written, then read without a write, comes back intact
  a_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(wr_fire) && !wr_fire && bus_addr == $past(bus_addr))
      |=> bus_rdata == $past(bus_wdata, 2));

endmodule

bind lcdpal_lookup lcdpal_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_fire    (lk_fire),
  .lk_valid_o (lk_valid_o),
  .depth_sel  (depth_sel),
  .lk_color   (lk_color),
  .wr_fire    (wr_fire),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata)
);

// File: tb/sim_lcdpal_lookup.sv
module sim_lcdpal_lookup;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  depth_sel = 2'd0;
  logic        lk_req = 1'b0;
  logic [7:0]  lk_index = '0;
  logic        lk_valid_o;
  logic [23:0] lk_color;

  always #4 clk = ~clk;

  lcdpal_lookup u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .depth_sel(depth_sel),
    .lk_req(lk_req), .lk_index(lk_index), .lk_valid_o(lk_valid_o),
    .lk_color(lk_color)
  );

  int checks = 0;
  int errors = 0;
  bit running = 0;

  logic [31:0] model [128];

  // pending items (pushed this cycle) and live items (due at next negedge)
  logic [23:0] pc_q[$]; string pct_q[$];
  logic [31:0] pr_q[$]; string prt_q[$];
  logic [23:0] lc_q[$]; string lct_q[$];
  logic [31:0] lr_q[$]; string lrt_q[$];

  function automatic logic [23:0] ref_color(input logic [15:0] e, input logic [1:0] d);
    int r, g, b;
    r = (e % 32) * 8;
    g = ((e / 32) % 32) * 8;
    b = ((e / 1024) % 32) * 8;
    case (d)
      2'd0: return 24'((r / 32) * 32 + (g / 32) * 4 + b / 64);
      2'd1: return 24'((r / 8) * 1024 + (g / 8) * 32 + b / 8);
      2'd2: return 24'((r / 8) * 2048 + (g / 4) * 32 + b / 8);
      default: return 24'(r * 65536 + g * 256 + b);
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one clock cycle of stimulus, expected items pushed to the scoreboard
  task automatic step(input bit we, input logic [6:0] a, input logic [31:0] d,
                      input bit lv, input logic [7:0] idx, input string tag);
    logic [31:0] w;
    @(posedge clk); #1;
    bus_we = we; bus_addr = a; bus_wdata = d; lk_req = lv; lk_index = idx;
    if (lv) begin
      w = model[idx[7:1]];
      pc_q.push_back(ref_color(idx[0] ? w[31:16] : w[15:0], depth_sel));
      pct_q.push_back(tag);
    end
    pr_q.push_back(model[a]);
    prt_q.push_back(tag);
    if (we) model[a] = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 7'd0, 32'd0, 0, 8'd0, "R10 idle");
  endtask

  // Monitor: move pending to live at each edge, compare at the falling edge
  always @(posedge clk) begin
    while (pc_q.size() > 0) begin lc_q.push_back(pc_q.pop_front()); lct_q.push_back(pct_q.pop_front()); end
    while (pr_q.size() > 0) begin lr_q.push_back(pr_q.pop_front()); lrt_q.push_back(prt_q.pop_front()); end
  end

  always @(negedge clk) begin
    if (running) begin
      if (lr_q.size() > 0) check(lrt_q.pop_front(), bus_rdata, lr_q.pop_front());
      if (lk_valid_o) begin
        if (lc_q.size() > 0) check(lct_q.pop_front(), {8'd0, lk_color}, {8'd0, lc_q.pop_front()});
        else check("R8 unexpected valid", 32'd1, 32'd0);
      end else if (lc_q.size() > 0) begin
        check(lct_q.pop_front(), 32'd0, 32'd1);
        void'(lc_q.pop_front());
      end
    end
  end

  bit done = 0;

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'd0);
    check("R1 valid after reset", {31'd0, lk_valid_o}, 32'd0);
    running = 1;

    // R1: fresh memory looks up as zero
    step(0, 7'd0, 0, 1, 8'd0, "R1 lookup zero");
    step(0, 7'd127, 0, 1, 8'd255, "R1 lookup zero top");
    idle(1);

    // R2, R3, R4: distinct halves, intensity bits set on one side
    step(1, 7'd3, 32'h7C1F_83E0, 0, 8'd0, "R2 write");
    step(1, 7'd4, 32'hA955_2AAA, 0, 8'd0, "R3 write");
    step(1, 7'd5, 32'h0C63_F39C, 0, 8'd0, "R4 write");
    step(0, 7'd5, 0, 1, 8'd6, "R2 even half");
    step(0, 7'd4, 0, 1, 8'd7, "R2 odd half");
    step(0, 7'd3, 0, 1, 8'd8, "R3 intensity ignored");
    step(0, 7'd0, 0, 1, 8'd9, "R3 channels");
    step(0, 7'd0, 0, 1, 8'd10, "R4 byte fmt");
    step(0, 7'd0, 0, 1, 8'd11, "R4 byte fmt odd");
    idle(2);

    // R11: full word readback including bits 15 and 31
    step(1, 7'd9, 32'h8000_8000, 0, 8'd0, "R11 write");
    step(0, 7'd9, 0, 1, 8'd18, "R11 readback");
    step(0, 7'd9, 0, 1, 8'd19, "R3 intensity only");
    idle(2);

    for (int d = 1; d < 4; d++) begin
      depth_sel = 2'(d);
      for (int k = 6; k < 12; k++)
        step(0, 7'd0, 0, 1, 8'(k),
             d == 1 ? "R5 fmt555" : (d == 2 ? "R6 fmt565" : "R7 fmt888"));
      step(0, 7'd0, 0, 1, 8'd18, "R3 intensity only");
      idle(2);
    end

    // R9: same-cycle write and lookup to one word
    depth_sel = 2'd3;
    step(1, 7'd10, 32'h1234_5678, 0, 8'd0, "R9 preload");
    step(1, 7'd10, 32'h7FFF_0421, 1, 8'd20, "R9 old value");
    step(0, 7'd10, 0, 1, 8'd20, "R9 new value");
    step(1, 7'd10, 32'h0000_0000, 1, 8'd21, "R9 old odd");
    step(0, 7'd10, 0, 1, 8'd21, "R9 new odd");
    // R10: read during write returns old word
    step(1, 7'd11, 32'hDEAD_BEEF, 0, 8'd0, "R10 read during write");
    step(1, 7'd11, 32'h0BAD_F00D, 0, 8'd0, "R10 read during write 2");
    step(0, 7'd11, 0, 0, 8'd0, "R10 read after write");
    // R8: back-to-back lookups and gaps
    step(0, 7'd0, 0, 1, 8'd22, "R8 burst");
    step(0, 7'd0, 0, 1, 8'd23, "R8 burst");
    step(0, 7'd0, 0, 0, 8'd0, "R8 gap");
    step(0, 7'd0, 0, 1, 8'd6, "R8 after gap");
    idle(3);
    check("R8 drained", lc_q.size() + pc_q.size(), 32'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule